// File: doc/BRIEF.md
# NAND Flash Host Command Sequencer

This block sits on the host side of an 8-bit NAND flash bus. It takes one operation request at a time (page read, page program, block erase, identification read or status read) and turns it into the matching series of bus cycles. Each request begins with a command-latch cycle. Address cycles, data-in cycles, a confirm command and serial read strobes follow as the operation needs them. The chip enable stays low for the whole operation. Command and address cycles raise the command-latch or address-latch line, and the write strobe is pulsed for every byte put on the I/O bus.

Once a command sets the device working, the sequencer watches the open-drain ready/busy line through a two-flop synchronizer. It does not go on until the line has been high for at least a settle window. If the line stays low past a programmable limit, the operation ends with a timeout flag. Program and erase finish with an automatic status read, and bit 0 of the status byte gives pass or fail. Page read, identification and status bytes come out on a one-byte valid stream. Program data is pulled from the host one byte at a time through a take strobe. Strobe low and high widths are parameters counted in clock cycles.

Top module: `nand_seq`

## Requirements
- R1: A read request (op 0) sends command 00h, 01h or 50h for `req_ptr` 0, 1 or 2-3. It then sends three address bytes in the order `req_addr[7:0]`, `[15:8]`, `[23:16]`, waits for ready/busy to be high, and returns `req_len` bytes on `rd_valid`/`rd_data`, one per read strobe.
- R2: A program request (op 1) sends 80h, then the three address bytes of R1, then `req_len` bytes taken from `wd_data` (`wd_take` pulses once per byte), then 10h. After ready/busy it sends 70h, reads one status byte, and reports `fail` equal to bit 0 of that byte when `done` is high.
- R3: An erase request (op 2) sends 60h, then `req_addr[15:8]` and `req_addr[23:16]` as address bytes, then D0h. It then waits and does the status read of R2, with `fail` reported the same way.
- R4: An identification request (op 3) sends 90h and one address byte of 00h, then streams two read bytes without waiting on ready/busy.
- R5: A status request (op 4; codes 5 to 7 act the same) sends 70h and streams one read byte.
- R6: Each write strobe is low for exactly `WP_CYC` clocks and each read strobe for exactly `RP_CYC` clocks. The latch lines and I/O data are held for `WH_CYC`/`RH_CYC` clocks after the rising edge. A strobe only falls after at least one idle clock.
- R7: The write and read strobes are never low together. `io_oe` is high on every write-strobe rising edge and low whenever the read strobe is low.
- R8: While the synchronized ready/busy line is low, `req_ready` is low, no request is accepted and no strobe is issued while a wait is in progress.
- R9: If ready/busy stays low for `TMO_CYC` clocks of a wait, the operation ends with `done` and `tmo_err` high, and no further bus cycle is issued.
- R10: In reset, `ce_n`, `we_n` and `re_n` are high, `cle`, `ale` and `io_oe` are low, and `req_ready` is high once reset is released with ready/busy high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle when high with req_valid |
| req_op | input | 3 | 0 read, 1 program, 2 erase, 3 ID, 4-7 status |
| req_ptr | input | 2 | Read area selector (0, 1, 2-3) |
| req_addr | input | 24 | Column byte then two row bytes |
| req_len | input | LEN_W | Byte count for read and program |
| wd_data | input | 8 | Current program byte from host |
| wd_take | output | 1 | Program byte consumed |
| rd_valid | output | 1 | Read byte valid |
| rd_data | output | 8 | Read byte |
| done | output | 1 | Operation finished (one cycle) |
| fail | output | 1 | Status bit 0 of program/erase, valid with done |
| tmo_err | output | 1 | Busy timeout, valid with done |
| ce_n | output | 1 | Chip enable, active low |
| cle | output | 1 | Command latch enable |
| ale | output | 1 | Address latch enable |
| we_n | output | 1 | Write strobe, active low |
| re_n | output | 1 | Read strobe, active low |
| io_out | output | 8 | Byte driven onto the I/O bus |
| io_oe | output | 1 | I/O bus drive enable |
| io_in | input | 8 | Byte sampled from the I/O bus |
| rb_n | input | 1 | Ready/busy, low while busy |

## Verification
A small flash model answers the bus, and every latched byte is compared in order against a queue of expected command, address and data bytes. Reads run with all three pointer commands and different column bases, so a wrong command byte or a wrong address order shows up as a different data pattern. Program and erase each run once with a passing and once with a failing status byte, which separates a correct bit-0 decode from a stuck flag. A long busy period checks the timeout path against a normal wait. An external busy held during idle checks that a pending request stays blocked until the line is released.

// File: rtl/nseq_pkg.sv
`timescale 1ns/1ps
// Shared types and constants for the NAND command sequencer.
package nseq_pkg;
    localparam int BYTE_W      = 8;
    localparam int ADDR_CYCLES = 3;

    typedef enum logic [2:0] {
        OP_READ   = 3'd0,
        OP_PROG   = 3'd1,
        OP_ERASE  = 3'd2,
        OP_ID     = 3'd3,
        OP_STATUS = 3'd4
    } nseq_op_e;

    typedef enum logic [3:0] {
        S_IDLE, S_CMD, S_ADDR, S_WDATA, S_CONF,
        S_WAIT, S_RDATA, S_SCMD, S_SRD, S_END
    } nseq_st_e;

    localparam logic [7:0] CMD_RD_A   = 8'h00;
    localparam logic [7:0] CMD_RD_B   = 8'h01;
    localparam logic [7:0] CMD_RD_C   = 8'h50;
    localparam logic [7:0] CMD_PROG   = 8'h80;
    localparam logic [7:0] CMD_PCONF  = 8'h10;
    localparam logic [7:0] CMD_ERASE  = 8'h60;
    localparam logic [7:0] CMD_ECONF  = 8'hD0;
    localparam logic [7:0] CMD_ID     = 8'h90;
    localparam logic [7:0] CMD_STATUS = 8'h70;
endpackage

// File: rtl/nseq_strobe.sv
`timescale 1ns/1ps
// Strobe generator: one write or read strobe per start request.
// Low phase then a hold phase; fin marks the last hold cycle and sample
// the last low cycle of a read. Assumes start only arrives while idle.
module nseq_strobe #(
    parameter int WR_LOW  = 5,
    parameter int WR_HIGH = 4,
    parameter int RD_LOW  = 5,
    parameter int RD_HIGH = 4,
    localparam int MAXC   = (WR_LOW > WR_HIGH ? WR_LOW : WR_HIGH) > (RD_LOW > RD_HIGH ? RD_LOW : RD_HIGH)
                          ? (WR_LOW > WR_HIGH ? WR_LOW : WR_HIGH) : (RD_LOW > RD_HIGH ? RD_LOW : RD_HIGH),
    localparam int CW     = $clog2(MAXC + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic is_rd,
    output logic we_n,
    output logic re_n,
    output logic idle,
    output logic fin,
    output logic sample
);
    typedef enum logic [1:0] {P_IDLE, P_LOW, P_HIGH} ph_e;
    ph_e           ph;
    logic [CW-1:0] cnt;
    logic          rd;

    // Phase and width counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph  <= P_IDLE;
            cnt <= '0;
            rd  <= 1'b0;
        end else begin
            case (ph)
                P_IDLE: if (start) begin
                    ph  <= P_LOW;
                    rd  <= is_rd;
                    cnt <= is_rd ? CW'(RD_LOW - 1) : CW'(WR_LOW - 1);
                end
                P_LOW: if (cnt == '0) begin
                    ph  <= P_HIGH;
                    cnt <= rd ? CW'(RD_HIGH - 1) : CW'(WR_HIGH - 1);
                end else cnt <= cnt - 1'b1;
                default: if (cnt == '0) ph <= P_IDLE;
                         else cnt <= cnt - 1'b1;
            endcase
        end
    end

    // Strobe outputs and phase flags.
    always_comb begin
        we_n   = !(ph == P_LOW && !rd);
        re_n   = !(ph == P_LOW && rd);
        idle   = (ph == P_IDLE);
        fin    = (ph == P_HIGH) && (cnt == '0);
        sample = (ph == P_LOW) && (cnt == '0) && rd;
    end

    assert_fall_after_gap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(we_n) || $fell(re_n)) |-> ($past(ph) == P_IDLE));
    assert_start_when_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ph == P_LOW && $past(ph) == P_IDLE) |-> $past(start));
endmodule

// File: rtl/nseq_rbwait.sv
`timescale 1ns/1ps
// Ready/busy watcher: synchronizes the open-drain busy line and, while
// active, reports done once the settle window has passed and the line is
// high, or a timeout after TMO_CYC cycles. Assumes TMO_CYC > WB_CYC.
module nseq_rbwait #(
    parameter int WB_CYC  = 4,
    parameter int TMO_CYC = 4000,
    localparam int CW     = $clog2(TMO_CYC + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    input  logic rb_n,
    output logic rb_ok,
    output logic done_o,
    output logic tmo_o
);
    logic          s1, s2;
    logic [CW-1:0] cnt;

    // Two-flop synchronizer, reset to ready.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1 <= 1'b1;
            s2 <= 1'b1;
        end else begin
            s1 <= rb_n;
            s2 <= s1;
        end
    end

    // Wait-length counter, saturating at the timeout.
    always_ff @(posedge clk) begin
        if (!rst_n)                  cnt <= '0;
        else if (!active)            cnt <= '0;
        else if (cnt != CW'(TMO_CYC)) cnt <= cnt + 1'b1;
    end

    // Result flags.
    always_comb begin
        rb_ok  = s2;
        done_o = active && (cnt >= CW'(WB_CYC)) && s2;
        tmo_o  = active && (cnt == CW'(TMO_CYC)) && !done_o;
    end

    assert_tmo_leaves_wait_R9: assert property (@(posedge clk) disable iff (!rst_n)
        tmo_o |=> !active);
endmodule

// File: rtl/nand_seq.sv
`timescale 1ns/1ps
// NAND flash host command sequencer (top).
// Turns one request into command/address/data/confirm bus cycles, waits on
// ready/busy, streams read bytes and reports status. Assumes the host keeps
// wd_data at the next program byte after each wd_take pulse.
module nand_seq import nseq_pkg::*; #(
    parameter int PAGE_BYTES = 528,
    parameter int WP_CYC     = 5,
    parameter int WH_CYC     = 4,
    parameter int RP_CYC     = 5,
    parameter int RH_CYC     = 4,
    parameter int WB_CYC     = 4,
    parameter int TMO_CYC    = 4000,
    localparam int LEN_W     = $clog2(PAGE_BYTES + 1),
    localparam int ADDR_W    = BYTE_W * ADDR_CYCLES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [2:0]        req_op,
    input  logic [1:0]        req_ptr,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [LEN_W-1:0]  req_len,
    input  logic [BYTE_W-1:0] wd_data,
    output logic              wd_take,
    output logic              rd_valid,
    output logic [BYTE_W-1:0] rd_data,
    output logic              done,
    output logic              fail,
    output logic              tmo_err,
    output logic              ce_n,
    output logic              cle,
    output logic              ale,
    output logic              we_n,
    output logic              re_n,
    output logic [BYTE_W-1:0] io_out,
    output logic              io_oe,
    input  logic [BYTE_W-1:0] io_in,
    input  logic              rb_n
);
    nseq_st_e          state;
    nseq_op_e          op_r;
    logic [1:0]        ptr_r;
    logic [ADDR_W-1:0] addr_r;
    logic [LEN_W-1:0]  len_r, idx;
    logic              fail_r, tmo_r, rd_valid_r;
    logic [BYTE_W-1:0] rd_data_r, cmd_byte, addr_byte;
    logic [1:0]        last_addr;
    logic              bus_st, rd_st, start, p_idle, fin, sample;
    logic              rb_ok, wait_done, wait_tmo;

    nseq_strobe #(.WR_LOW(WP_CYC), .WR_HIGH(WH_CYC), .RD_LOW(RP_CYC), .RD_HIGH(RH_CYC)) u_strobe (
        .clk(clk), .rst_n(rst_n), .start(start), .is_rd(rd_st),
        .we_n(we_n), .re_n(re_n), .idle(p_idle), .fin(fin), .sample(sample));

    nseq_rbwait #(.WB_CYC(WB_CYC), .TMO_CYC(TMO_CYC)) u_rbwait (
        .clk(clk), .rst_n(rst_n), .active(state == S_WAIT), .rb_n(rb_n),
        .rb_ok(rb_ok), .done_o(wait_done), .tmo_o(wait_tmo));

    // Byte selection for command and address cycles.
    always_comb begin
        case (state)
            S_CMD: case (op_r)
                OP_READ:  cmd_byte = (ptr_r == 2'd0) ? CMD_RD_A : (ptr_r == 2'd1) ? CMD_RD_B : CMD_RD_C;
                OP_PROG:  cmd_byte = CMD_PROG;
                OP_ERASE: cmd_byte = CMD_ERASE;
                OP_ID:    cmd_byte = CMD_ID;
                default:  cmd_byte = CMD_STATUS;
            endcase
            S_CONF:  cmd_byte = (op_r == OP_PROG) ? CMD_PCONF : CMD_ECONF;
            default: cmd_byte = CMD_STATUS;
        endcase
        case (op_r)
            OP_ID:    addr_byte = 8'h00;
            OP_ERASE: addr_byte = idx[0] ? addr_r[23:16] : addr_r[15:8];
            default: case (idx[1:0])
                2'd0:    addr_byte = addr_r[7:0];
                2'd1:    addr_byte = addr_r[15:8];
                default: addr_byte = addr_r[23:16];
            endcase
        endcase
        last_addr = (op_r == OP_ERASE) ? 2'd1 : (op_r == OP_ID) ? 2'd0 : 2'd2;
    end

    // Bus control decode.
    always_comb begin
        rd_st     = (state == S_RDATA) || (state == S_SRD);
        bus_st    = rd_st || (state == S_CMD) || (state == S_ADDR) || (state == S_WDATA)
                 || (state == S_CONF) || (state == S_SCMD);
        start     = bus_st && p_idle;
        cle       = (state == S_CMD) || (state == S_CONF) || (state == S_SCMD);
        ale       = (state == S_ADDR);
        io_oe     = bus_st && !rd_st;
        io_out    = (state == S_ADDR) ? addr_byte : (state == S_WDATA) ? wd_data : cmd_byte;
        ce_n      = (state == S_IDLE) || (state == S_END);
        req_ready = (state == S_IDLE) && rb_ok;
        wd_take   = fin && (state == S_WDATA);
        done      = (state == S_END);
        fail      = fail_r;
        tmo_err   = tmo_r;
        rd_valid  = rd_valid_r;
        rd_data   = rd_data_r;
    end

    // Operation sequencing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= S_IDLE;
            op_r   <= OP_STATUS;
            ptr_r  <= '0;
            addr_r <= '0;
            len_r  <= '0;
            idx    <= '0;
            fail_r <= 1'b0;
            tmo_r  <= 1'b0;
        end else begin
            case (state)
                S_IDLE: if (req_valid && req_ready) begin
                    op_r   <= (req_op > 3'd4) ? OP_STATUS : nseq_op_e'(req_op);
                    ptr_r  <= req_ptr;
                    addr_r <= req_addr;
                    idx    <= '0;
                    fail_r <= 1'b0;
                    tmo_r  <= 1'b0;
                    len_r  <= (req_op == 3'd3) ? LEN_W'(2)
                            : (req_op == 3'd0 || req_op == 3'd1) ? req_len : LEN_W'(1);
                    state  <= S_CMD;
                end
                S_CMD: if (fin) state <= (op_r == OP_STATUS) ? S_RDATA : S_ADDR;
                S_ADDR: if (fin) begin
                    if (idx[1:0] == last_addr) begin
                        idx <= '0;
                        case (op_r)
                            OP_READ:  state <= S_WAIT;
                            OP_PROG:  state <= (len_r == '0) ? S_CONF : S_WDATA;
                            OP_ERASE: state <= S_CONF;
                            default:  state <= S_RDATA;
                        endcase
                    end else idx <= idx + 1'b1;
                end
                S_WDATA: if (fin) begin
                    if (idx == len_r - LEN_W'(1)) begin
                        idx   <= '0;
                        state <= S_CONF;
                    end else idx <= idx + 1'b1;
                end
                S_CONF: if (fin) state <= S_WAIT;
                S_WAIT: begin
                    if (wait_done)
                        state <= (op_r != OP_READ) ? S_SCMD : (len_r == '0) ? S_END : S_RDATA;
                    else if (wait_tmo) begin
                        tmo_r <= 1'b1;
                        state <= S_END;
                    end
                end
                S_RDATA: if (fin) begin
                    if (idx == len_r - LEN_W'(1)) begin
                        idx   <= '0;
                        state <= S_END;
                    end else idx <= idx + 1'b1;
                end
                S_SCMD: if (fin) state <= S_SRD;
                S_SRD: begin
                    if (sample) fail_r <= io_in[0];
                    if (fin) state <= S_END;
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    // Read byte capture into the output stream.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid_r <= 1'b0;
            rd_data_r  <= '0;
        end else begin
            rd_valid_r <= sample && (state == S_RDATA);
            if (sample && (state == S_RDATA)) rd_data_r <= io_in;
        end
    end

    assert_no_overlap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(!we_n && !re_n));
    assert_float_on_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !re_n |-> !io_oe);
    assert_idle_blocked_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IDLE && !rb_ok) |=> (state == S_IDLE));
    assert_quiet_in_wait_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_WAIT) |-> (we_n && re_n));
    assert_ce_with_strobe_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!we_n || !re_n) |-> !ce_n);
endmodule

// File: tb/nand_seq_test.sv
`timescale 1ns/1ps
// Scoreboard bench: driver tasks queue expected bus bytes and read bytes;
// monitors pop and compare as the sequencer produces them.
module nand_seq_test;
    localparam int WP = 5, WH = 4, RP = 5, RH = 4, WB = 4, TMO = 400;
    localparam real CLK = 5.0;

    logic clk = 0, rst_n = 0;
    logic req_valid = 0, req_ready;
    logic [2:0] req_op = 0;
    logic [1:0] req_ptr = 0;
    logic [23:0] req_addr = 0;
    logic [9:0] req_len = 0;
    logic [7:0] wd_data, rd_data, io_out, io_in;
    logic wd_take, rd_valid, done, fail, tmo_err;
    logic ce_n, cle, ale, we_n, re_n, io_oe, rb_n;

    int checks = 0, errors = 0;
    logic [10:0] exp_bus[$];
    logic [7:0]  exp_rd[$];
    string       exp_rd_tag[$];
    int widx = 0, we_falls = 0, overlap = 0;
    int kick = 0, kick_seen = 0, busy_cnt = 0, busy_len = 40;
    logic ext_busy = 0;
    realtime t_we = 0, t_re = 0;
    logic [7:0] m_cmd = 8'hFF, m_col = 0, status_val = 8'hC0;
    int m_addr_n = 0, m_ridx = 0;

    always #2.5 clk = ~clk;

    nand_seq #(.WP_CYC(WP), .WH_CYC(WH), .RP_CYC(RP), .RH_CYC(RH), .WB_CYC(WB), .TMO_CYC(TMO)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
        .req_ptr(req_ptr), .req_addr(req_addr), .req_len(req_len), .wd_data(wd_data),
        .wd_take(wd_take), .rd_valid(rd_valid), .rd_data(rd_data), .done(done), .fail(fail),
        .tmo_err(tmo_err), .ce_n(ce_n), .cle(cle), .ale(ale), .we_n(we_n), .re_n(re_n),
        .io_out(io_out), .io_oe(io_oe), .io_in(io_in), .rb_n(rb_n));

    function automatic logic [7:0] page_byte(logic [7:0] cmd, logic [7:0] col, int i);
        return (col + 8'(i)) ^ cmd ^ 8'h3C;
    endfunction

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Flash model: data returned on the I/O bus.
    always_comb begin
        case (m_cmd)
            8'h90:   io_in = (m_ridx == 0) ? 8'hEC : 8'h73;
            8'h70:   io_in = status_val;
            default: io_in = page_byte(m_cmd, m_col, m_ridx);
        endcase
    end
    assign wd_data = 8'h90 + 8'(widx);
    assign rb_n = !((busy_cnt > 0) || ext_busy);

    always @(posedge clk) if (wd_take) widx <= widx + 1;
    always @(posedge clk) begin
        if (kick != kick_seen) begin kick_seen <= kick; busy_cnt <= busy_len; end
        else if (busy_cnt > 0) busy_cnt <= busy_cnt - 1;
    end
    always @(negedge clk) if (rst_n && !we_n && !re_n) overlap++;

    always @(negedge we_n) if (rst_n) begin t_we = $realtime; we_falls++; end
    // Write-cycle monitor: width, expected byte, model update.
    always @(posedge we_n) if (rst_n) begin
        logic [10:0] e;
        check(int'(($realtime - t_we) * 10) == WP * 50, "R6 write strobe width",
              int'(($realtime - t_we) * 10), WP * 50);
        if (exp_bus.size() == 0) check(0, "R1 unexpected bus cycle", {io_oe, cle, ale, io_out}, 0);
        else begin
            e = exp_bus.pop_front();
            check({io_oe, cle, ale, io_out} == e, "R1/R2/R3/R4/R5/R7 bus byte", {io_oe, cle, ale, io_out}, e);
        end
        if (cle) begin
            m_cmd = io_out; m_addr_n = 0; m_ridx = 0;
            if (io_out == 8'h10 || io_out == 8'hD0) kick++;
        end else if (ale) begin
            if (m_addr_n == 0) m_col = io_out;
            m_addr_n++;
            if ((m_cmd == 8'h00 || m_cmd == 8'h01 || m_cmd == 8'h50) && m_addr_n == 3) kick++;
        end
    end

    always @(negedge re_n) if (rst_n) begin
        t_re = $realtime;
        check(rb_n == 1'b1, "R8 read strobe while busy", rb_n, 1);
    end
    always @(posedge re_n) if (rst_n) begin
        check(int'(($realtime - t_re) * 10) == RP * 50, "R6 read strobe width",
              int'(($realtime - t_re) * 10), RP * 50);
        check(io_oe == 1'b0, "R7 bus driven during read", io_oe, 0);
        m_ridx++;
    end

    // Read stream monitor.
    always @(negedge clk) if (rst_n && rd_valid) begin
        if (exp_rd.size() == 0) check(0, "R1 unexpected read byte", rd_data, 0);
        else begin
            logic [7:0] e;
            string t;
            e = exp_rd.pop_front();
            t = exp_rd_tag.pop_front();
            check(rd_data == e, t, rd_data, e);
        end
    end

    task automatic push_bus(input logic [1:0] ca, input logic [7:0] b);
        exp_bus.push_back({1'b1, ca, b});
    endtask

    task automatic issue(input logic [2:0] op, input logic [1:0] ptr, input logic [23:0] a, input int len);
        req_op = op; req_ptr = ptr; req_addr = a; req_len = 10'(len); req_valid = 1;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 0;
    endtask

    task automatic wait_done(input bit efail, input bit etmo, input string tag);
        while (!done) @(negedge clk);
        check(fail == efail, {tag, " fail flag"}, fail, efail);
        check(tmo_err == etmo, {tag, " timeout flag"}, tmo_err, etmo);
        @(negedge clk);
    endtask

    task automatic do_read(input logic [1:0] ptr, input logic [23:0] a, input int len);
        logic [7:0] c;
        c = (ptr == 0) ? 8'h00 : (ptr == 1) ? 8'h01 : 8'h50;
        push_bus(2'b10, c);
        push_bus(2'b01, a[7:0]); push_bus(2'b01, a[15:8]); push_bus(2'b01, a[23:16]);
        for (int i = 0; i < len; i++) begin
            exp_rd.push_back(page_byte(c, a[7:0], i)); exp_rd_tag.push_back("R1 page read byte");
        end
        issue(3'd0, ptr, a, len);
        wait_done(0, 0, "R1");
        check(exp_bus.size() == 0 && exp_rd.size() == 0, "R1 read sequence complete", exp_rd.size(), 0);
    endtask

    task automatic do_prog(input logic [23:0] a, input int len, input logic [7:0] st);
        status_val = st;
        push_bus(2'b10, 8'h80);
        push_bus(2'b01, a[7:0]); push_bus(2'b01, a[15:8]); push_bus(2'b01, a[23:16]);
        for (int i = 0; i < len; i++) push_bus(2'b00, 8'h90 + 8'(widx + i));
        push_bus(2'b10, 8'h10); push_bus(2'b10, 8'h70);
        issue(3'd1, 0, a, len);
        wait_done(st[0], 0, "R2");
        check(exp_bus.size() == 0, "R2 program sequence complete", exp_bus.size(), 0);
    endtask

    task automatic do_erase(input logic [23:0] a, input logic [7:0] st);
        status_val = st;
        push_bus(2'b10, 8'h60); push_bus(2'b01, a[15:8]); push_bus(2'b01, a[23:16]);
        push_bus(2'b10, 8'hD0); push_bus(2'b10, 8'h70);
        issue(3'd2, 0, a, 0);
        wait_done(st[0], 0, "R3");
        check(exp_bus.size() == 0, "R3 erase sequence complete", exp_bus.size(), 0);
    endtask

    task automatic finish_run;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        check(0, "watchdog expired", 0, 1);
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        check({ce_n, we_n, re_n} == 3'b111 && {cle, ale, io_oe} == 3'b000, "R10 reset outputs",
              {ce_n, we_n, re_n, cle, ale, io_oe}, 6'b111000);
        rst_n = 1;
        repeat (3) @(negedge clk);
        check(req_ready == 1'b1, "R10 ready after reset", req_ready, 1);

        // R4: identification read.
        push_bus(2'b10, 8'h90); push_bus(2'b01, 8'h00);
        exp_rd.push_back(8'hEC); exp_rd_tag.push_back("R4 maker byte");
        exp_rd.push_back(8'h73); exp_rd_tag.push_back("R4 device byte");
        issue(3'd3, 0, 24'hABCDEF, 0);
        wait_done(0, 0, "R4");

        // R5: status read, plain and alias code.
        status_val = 8'hC0;
        push_bus(2'b10, 8'h70); exp_rd.push_back(8'hC0); exp_rd_tag.push_back("R5 status byte");
        issue(3'd4, 0, 0, 0);
        wait_done(0, 0, "R5");
        status_val = 8'hE1;
        push_bus(2'b10, 8'h70); exp_rd.push_back(8'hE1); exp_rd_tag.push_back("R5 status alias code");
        issue(3'd7, 0, 0, 0);
        wait_done(0, 0, "R5");

        // R1: reads through all three pointer commands.
        do_read(2'd0, 24'h345612, 4);
        do_read(2'd1, 24'h0102F0, 3);
        do_read(2'd2, 24'h7F0005, 2);

        // R2 and R3: pass and fail status.
        do_prog(24'h001122, 5, 8'hC0);
        do_prog(24'h00AA40, 3, 8'hC1);
        do_erase(24'h5A3C00, 8'hC0);
        do_erase(24'h123400, 8'hC1);

        // R9: busy outlasts the timeout.
        busy_len = TMO + 200;
        push_bus(2'b10, 8'h00);
        push_bus(2'b01, 8'h10); push_bus(2'b01, 8'h20); push_bus(2'b01, 8'h30);
        issue(3'd0, 0, 24'h302010, 2);
        wait_done(0, 1, "R9");
        begin
            int f0;
            f0 = we_falls;
            repeat (20) @(negedge clk);
            check(we_falls == f0 && exp_rd.size() == 0, "R9 no cycles after timeout", we_falls - f0, 0);
        end
        busy_len = 40;
        while (!req_ready) @(negedge clk);

        // R8: external busy blocks a pending request.
        ext_busy = 1;
        repeat (3) @(negedge clk);
        check(req_ready == 1'b0, "R8 ready low while busy", req_ready, 0);
        status_val = 8'hC0;
        push_bus(2'b10, 8'h70); exp_rd.push_back(8'hC0); exp_rd_tag.push_back("R8 request after release");
        begin
            int f0;
            f0 = we_falls;
            req_op = 3'd4; req_valid = 1;
            repeat (10) @(negedge clk);
            check(we_falls == f0 && ce_n == 1'b1, "R8 no cycle while busy", we_falls - f0, 0);
        end
        ext_busy = 0;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 0;
        wait_done(0, 0, "R8");

        check(exp_bus.size() == 0 && exp_rd.size() == 0, "R1 scoreboard drained",
              exp_bus.size() + exp_rd.size(), 0);
        check(overlap == 0, "R7 strobes never low together", overlap, 0);
        finish_run();
    end
endmodule